// File: doc/BRIEF.md
# Host SPI Register Port with Byte FIFO

This block is the host-facing control port of a contactless transceiver. An SPI master (mode 0, most significant bit first, active-low select) reaches a small bank of configuration registers, a two-byte transmit length register with a partial-last-byte descriptor, an interrupt status register and a byte FIFO behind a single window address. Every transaction opens with a control byte. That byte either names a register, in which case one data byte or a run of data bytes follows, or carries a direct command that restores the register defaults.

The SPI pins are sampled by the block's own clock, which must run well above the SCLK rate. The radio core reports the end of transmission, the start of reception and the end of reception as one-cycle pulses. These set status bits. Any status bit except the reception-start bit drives the interrupt line. The host clears the status bits by reading the status register, and the clear takes effect at the next deselect.

Top module: `xhp_host_port`

## Requirements
- R1: A transaction spans the time from a falling edge to the next rising edge of `spi_ss_n`. Its first byte is the control byte: bit 7 = 1 for a command, bit 6 = 1 for a read, bit 5 = 1 for continuous mode, bits 4..0 the address or command code. MISO returns 0x00 while the control byte is shifted in. After that it returns the byte addressed during the previous eight clocks, MSB first.
- R2: After reset, register 0x00 reads 0x01, 0x01 reads 0x21, 0x09 reads 0x11, every other register reads 0x00, the FIFO is empty and `irq` is low.
- R3: In single mode (bit 5 = 0) only the first data byte is written. Further write bytes are dropped. A single read returns the addressed byte and then 0x00 for any further bytes.
- R4: In continuous mode the address advances by one after every data byte, except that it stays at 0x1F once it reaches 0x1F.
- R5: Address 0x1F is a first-in first-out data port holding up to 127 bytes.
- R6: Register 0x1C reads {full, count[6:0]}, where bit 7 is 1 when 127 bytes are held. Writes to 0x1C are dropped.
- R7: Register 0x1D holds length bits 11..4. Register 0x1E holds length bits 3..0 in bits 7..4, the partial byte's bit count in bits 3..1 and the partial flag in bit 0. These values appear on `tx_len`, `tx_tail_bits` and `tx_tail_valid`.
- R8: A FIFO write while 127 bytes are held is dropped and sets status bit 4. A FIFO read while the FIFO is empty returns 0x00 and sets status bit 3. The prefetch after the last byte of a continuous FIFO read counts as such a read.
- R9: Register 0x0C holds the status bits: bit 7 end of transmit, bit 6 start of receive, bit 5 end of receive, bit 4 overflow, bit 3 underflow. `irq` is high while any of bits 7, 5, 4 or 3 is set. Bit 6 alone never raises `irq`. Writes to 0x0C are dropped.
- R10: Reading 0x0C clears, at the following rise of `spi_ss_n`, exactly the bits it returned. Bits set after the read survive the clear.
- R11: Commands 0x03 and 0x00 (control bytes 0x83 and 0x80) restore every register default, empty the FIFO and clear the status. Any other command code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_ss_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| evt_tx_end | input | 1 | Pulse: transmission finished |
| evt_rx_begin | input | 1 | Pulse: reception started |
| evt_rx_end | input | 1 | Pulse: reception finished |
| irq | output | 1 | Interrupt request, active high |
| tx_len | output | 12 | Byte count to transmit |
| tx_tail_bits | output | 3 | Valid bits in the partial last byte |
| tx_tail_valid | output | 1 | Last byte is partial |

## Verification
The case hardest to reach from the ports is a status event that arrives after the status register has been shifted out but before select rises. The bench reaches it by pulsing the transmit-end input while select is still held low after the status read. It then expects `irq` to stay high and the bit to remain readable. The FIFO limits also need long streams: 128 bytes in a single continuous write to hit the overflow, then a 127-byte continuous read whose trailing prefetch must register an underflow.

// File: rtl/xhp_pkg.sv
package xhp_pkg;

   localparam logic [4:0] A_STATUS = 5'h0C;
   localparam logic [4:0] A_FSTAT  = 5'h1C;
   localparam logic [4:0] A_LENHI  = 5'h1D;
   localparam logic [4:0] A_LENLO  = 5'h1E;
   localparam logic [4:0] A_WINDOW = 5'h1F;

   localparam logic [4:0] C_IDLE   = 5'h00;
   localparam logic [4:0] C_INIT   = 5'h03;

   localparam int S_TXEND = 7;
   localparam int S_RXBEG = 6;
   localparam int S_RXEND = 5;
   localparam int S_OVF   = 4;
   localparam int S_UNF   = 3;

   typedef struct packed {
      logic       is_cmd;
      logic       rd;
      logic       cont;
      logic [4:0] code;
   } ctl_t;

   typedef enum logic [1:0] {XM_IDLE, XM_WR, XM_RD, XM_SKIP} xfer_mode_e;

   function automatic logic [7:0] reg_default(input logic [4:0] a);
      case (a)
         5'h00:   return 8'h01;
         5'h01:   return 8'h21;
         5'h09:   return 8'h11;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [4:0] addr_step(input logic [4:0] a);
      return (a == A_WINDOW) ? A_WINDOW : 5'(a + 5'd1);
   endfunction

endpackage

// File: rtl/xhp_spi_shifter.sv
module xhp_spi_shifter #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sclk,
   input  logic       spi_ss_n,
   input  logic       spi_mosi,
   input  logic       load_en,
   input  logic [7:0] load_byte,
   output logic       spi_miso,
   output logic       ss_fall,
   output logic       ss_rise,
   output logic       byte_done,
   output logic [7:0] rx_byte
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xhp_spi_shifter: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sclk_sync, ss_sync, mosi_sync;
   logic                   sclk_d, ss_d;
   logic                   s_sclk, s_ss, s_mosi;
   logic                   sclk_rise, sclk_fall;
   logic [2:0]             bitcnt_q;
   logic [7:0]             rx_sr_q, tx_sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_sync <= '0;
         ss_sync   <= '1;
         mosi_sync <= '0;
         sclk_d    <= 1'b0;
         ss_d      <= 1'b1;
      end else begin
         sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], spi_sclk};
         ss_sync   <= {ss_sync[SYNC_STAGES-2:0], spi_ss_n};
         mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], spi_mosi};
         sclk_d    <= s_sclk;
         ss_d      <= s_ss;
      end
   end

   assign s_sclk    = sclk_sync[SYNC_STAGES-1];
   assign s_ss      = ss_sync[SYNC_STAGES-1];
   assign s_mosi    = mosi_sync[SYNC_STAGES-1];
   assign sclk_rise = s_sclk & ~sclk_d & ~s_ss;
   assign sclk_fall = ~s_sclk & sclk_d & ~s_ss;
   assign ss_fall   = ~s_ss & ss_d;
   assign ss_rise   = s_ss & ~ss_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt_q  <= '0;
         rx_sr_q   <= '0;
         tx_sr_q   <= '0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
      end else begin
         byte_done <= 1'b0;
         if (ss_fall) begin
            bitcnt_q <= '0;
            tx_sr_q  <= '0;
         end else if (sclk_rise) begin
            rx_sr_q  <= {rx_sr_q[6:0], s_mosi};
            bitcnt_q <= 3'(bitcnt_q + 3'd1);
            if (bitcnt_q == 3'd7) begin
               byte_done <= 1'b1;
               rx_byte   <= {rx_sr_q[6:0], s_mosi};
            end
         end else if (sclk_fall && bitcnt_q != 3'd0) begin
            tx_sr_q <= {tx_sr_q[6:0], 1'b0};
         end
         if (load_en) tx_sr_q <= load_byte;
      end
   end

   assign spi_miso = tx_sr_q[7] & ~s_ss;

   // R1: a new frame always starts counting bits from zero
   p_frame_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ss_fall |=> (bitcnt_q == 3'd0));
   // R1: a completed byte is reported for exactly one cycle
   p_byte_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);

endmodule

// File: rtl/xhp_byte_fifo.sv
module xhp_byte_fifo #(
   parameter int DEPTH = 127,
   parameter int DW    = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic [DW-1:0]                push_data,
   input  logic                         pop,
   output logic [DW-1:0]                rd_data,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full,
   output logic                         empty
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("xhp_byte_fifo: DEPTH must be at least 2");
   end

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;

   if (POW2) begin : g_wrap_free
      assign wr_nxt = PTR_W'(wr_ptr_q + 1'b1);
      assign rd_nxt = PTR_W'(rd_ptr_q + 1'b1);
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(wr_ptr_q + 1'b1);
      assign rd_nxt = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(rd_ptr_q + 1'b1);
   end

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign count   = cnt_q;
   assign rd_data = empty ? '0 : mem[rd_ptr_q];

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wr_ptr_q] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else if (clr) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_nxt;
         if (do_pop)  rd_ptr_q <= rd_nxt;
         cnt_q <= CNT_W'(cnt_q + CNT_W'(do_push) - CNT_W'(do_pop));
      end
   end

   // R8: a write into a full FIFO leaves the fill level unchanged
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (count == $past(count)));
   // R8: a read of an empty FIFO keeps it empty
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !clr) |=> empty);

endmodule

// File: rtl/xhp_regfile.sv
module xhp_regfile
   import xhp_pkg::*;
#(
   parameter int NUM_GEN = 28
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        wr_en,
   input  logic [4:0]  wr_addr,
   input  logic [7:0]  wr_data,
   input  logic [4:0]  rd_addr,
   output logic [7:0]  rd_data,
   input  logic        stat_read,
   input  logic        stat_commit,
   input  logic        evt_tx_end,
   input  logic        evt_rx_begin,
   input  logic        evt_rx_end,
   input  logic        set_ovf,
   input  logic        set_unf,
   output logic        irq,
   output logic [11:0] tx_len,
   output logic [2:0]  tx_tail_bits,
   output logic        tx_tail_valid
);

   localparam logic [7:0] IRQ_MASK = 8'((1 << S_TXEND) | (1 << S_RXEND) |
                                        (1 << S_OVF) | (1 << S_UNF));

   if (NUM_GEN < 1 || NUM_GEN > 28) begin : g_bad_gen
      $error("xhp_regfile: NUM_GEN must lie in 1..28");
   end

   logic [7:0] gen_q [NUM_GEN];
   logic [7:0] lenhi_q, lenlo_q;
   logic [7:0] stat_q, snap_q, stat_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_GEN; i++) gen_q[i] <= reg_default(5'(i));
         lenhi_q <= reg_default(A_LENHI);
         lenlo_q <= reg_default(A_LENLO);
      end else if (init) begin
         for (int i = 0; i < NUM_GEN; i++) gen_q[i] <= reg_default(5'(i));
         lenhi_q <= reg_default(A_LENHI);
         lenlo_q <= reg_default(A_LENLO);
      end else if (wr_en) begin
         for (int i = 0; i < NUM_GEN; i++) begin
            if (wr_addr == 5'(i) && wr_addr != A_STATUS) gen_q[i] <= wr_data;
         end
         if (wr_addr == A_LENHI) lenhi_q <= wr_data;
         if (wr_addr == A_LENLO) lenlo_q <= wr_data;
      end
   end

   always_comb begin
      stat_set          = '0;
      stat_set[S_TXEND] = evt_tx_end;
      stat_set[S_RXBEG] = evt_rx_begin;
      stat_set[S_RXEND] = evt_rx_end;
      stat_set[S_OVF]   = set_ovf;
      stat_set[S_UNF]   = set_unf;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         snap_q <= '0;
      end else if (init) begin
         stat_q <= '0;
         snap_q <= '0;
      end else begin
         if (stat_commit) begin
            stat_q <= (stat_q & ~snap_q) | stat_set;
            snap_q <= '0;
         end else begin
            stat_q <= stat_q | stat_set;
            if (stat_read) snap_q <= snap_q | stat_q;
         end
      end
   end

   always_comb begin
      case (rd_addr)
         A_STATUS: rd_data = stat_q;
         A_LENHI:  rd_data = lenhi_q;
         A_LENLO:  rd_data = lenlo_q;
         default:  rd_data = (int'(rd_addr) < NUM_GEN) ? gen_q[rd_addr] : 8'h00;
      endcase
   end

   assign irq           = |(stat_q & IRQ_MASK);
   assign tx_len        = {lenhi_q, lenlo_q[7:4]};
   assign tx_tail_bits  = lenlo_q[3:1];
   assign tx_tail_valid = lenlo_q[0];

   // R9: receive start on its own never raises the interrupt
   p_rxbeg_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_rx_begin && !evt_tx_end && !evt_rx_end && !set_ovf && !set_unf && !irq)
      |=> !irq);
   // R10: status bits are only removed at deselect or by a command
   p_clear_at_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_commit && !init) |=> (($past(stat_q) & ~stat_q) == 8'h00));
   // R11: a restore command brings back the defaults and clears status
   p_init_defaults_r11: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (gen_q[0] == reg_default(5'h00)) && (tx_len == 12'h000) && !irq);

endmodule

// File: rtl/xhp_host_port.sv
module xhp_host_port
   import xhp_pkg::*;
#(
   parameter int FIFO_DEPTH   = 127,
   parameter int SYNC_STAGES  = 2,
   parameter int NUM_GEN_REGS = 28
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        spi_sclk,
   input  logic        spi_ss_n,
   input  logic        spi_mosi,
   output logic        spi_miso,
   input  logic        evt_tx_end,
   input  logic        evt_rx_begin,
   input  logic        evt_rx_end,
   output logic        irq,
   output logic [11:0] tx_len,
   output logic [2:0]  tx_tail_bits,
   output logic        tx_tail_valid
);

   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH > 127) begin : g_bad_fifo
      $error("xhp_host_port: FIFO_DEPTH must fit the 7-bit level field");
   end

   logic        ss_fall, ss_rise, byte_done;
   logic [7:0]  rx_byte;
   logic        load_en;
   logic [7:0]  load_byte;
   ctl_t        ctl;
   logic [4:0]  cur_addr;
   logic [7:0]  rd_value, rf_rd_data, fstat;
   logic        wr_en, rd_live, init_cmd;
   logic        fifo_push, fifo_pop, fifo_full, fifo_empty;
   logic [7:0]  fifo_rd_data;
   logic [CNT_W-1:0] fifo_count;
   logic        rf_wr, stat_read, set_ovf, set_unf;

   logic        first_q, cont_q, spent_q;
   logic [4:0]  ptr_q;
   xfer_mode_e  mode_q;

   xhp_spi_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .spi_sclk  (spi_sclk),
      .spi_ss_n  (spi_ss_n),
      .spi_mosi  (spi_mosi),
      .load_en   (load_en),
      .load_byte (load_byte),
      .spi_miso  (spi_miso),
      .ss_fall   (ss_fall),
      .ss_rise   (ss_rise),
      .byte_done (byte_done),
      .rx_byte   (rx_byte)
   );

   assign ctl      = ctl_t'(rx_byte);
   assign cur_addr = first_q ? ctl.code : ptr_q;
   assign fstat    = {fifo_full, 7'(fifo_count)};

   always_comb begin
      case (cur_addr)
         A_WINDOW: rd_value = fifo_rd_data;
         A_FSTAT:  rd_value = fstat;
         default:  rd_value = rf_rd_data;
      endcase
   end

   always_comb begin
      load_en   = 1'b0;
      load_byte = 8'h00;
      wr_en     = 1'b0;
      init_cmd  = 1'b0;
      rd_live   = 1'b0;
      if (byte_done) begin
         if (first_q) begin
            if (ctl.is_cmd) begin
               init_cmd = (ctl.code == C_INIT) || (ctl.code == C_IDLE);
            end else if (ctl.rd) begin
               load_en   = 1'b1;
               rd_live   = 1'b1;
               load_byte = rd_value;
            end
         end else begin
            case (mode_q)
               XM_RD: begin
                  load_en   = 1'b1;
                  rd_live   = cont_q;
                  load_byte = cont_q ? rd_value : 8'h00;
               end
               XM_WR:   wr_en = cont_q || !spent_q;
               default: ;
            endcase
         end
      end
   end

   assign fifo_pop  = load_en && rd_live && (cur_addr == A_WINDOW);
   assign fifo_push = wr_en && (cur_addr == A_WINDOW);
   assign set_unf   = fifo_pop && fifo_empty;
   assign set_ovf   = fifo_push && fifo_full;
   assign rf_wr     = wr_en && (cur_addr != A_WINDOW);
   assign stat_read = load_en && rd_live && (cur_addr == A_STATUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 1'b1;
         cont_q  <= 1'b0;
         spent_q <= 1'b0;
         ptr_q   <= '0;
         mode_q  <= XM_IDLE;
      end else if (ss_fall) begin
         first_q <= 1'b1;
         spent_q <= 1'b0;
         mode_q  <= XM_IDLE;
      end else if (byte_done) begin
         if (first_q) begin
            first_q <= 1'b0;
            cont_q  <= ctl.cont;
            spent_q <= 1'b0;
            if (ctl.is_cmd)  mode_q <= XM_SKIP;
            else if (ctl.rd) mode_q <= XM_RD;
            else             mode_q <= XM_WR;
            ptr_q <= (!ctl.is_cmd && ctl.rd && ctl.cont) ? addr_step(ctl.code) : ctl.code;
         end else if (mode_q == XM_RD && cont_q) begin
            ptr_q <= addr_step(ptr_q);
         end else if (wr_en) begin
            spent_q <= 1'b1;
            if (cont_q) ptr_q <= addr_step(ptr_q);
         end
      end
   end

   xhp_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (init_cmd),
      .push      (fifo_push),
      .push_data (rx_byte),
      .pop       (fifo_pop),
      .rd_data   (fifo_rd_data),
      .count     (fifo_count),
      .full      (fifo_full),
      .empty     (fifo_empty)
   );

   xhp_regfile #(.NUM_GEN(NUM_GEN_REGS)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .init          (init_cmd),
      .wr_en         (rf_wr),
      .wr_addr       (cur_addr),
      .wr_data       (rx_byte),
      .rd_addr       (cur_addr),
      .rd_data       (rf_rd_data),
      .stat_read     (stat_read),
      .stat_commit   (ss_rise),
      .evt_tx_end    (evt_tx_end),
      .evt_rx_begin  (evt_rx_begin),
      .evt_rx_end    (evt_rx_end),
      .set_ovf       (set_ovf),
      .set_unf       (set_unf),
      .irq           (irq),
      .tx_len        (tx_len),
      .tx_tail_bits  (tx_tail_bits),
      .tx_tail_valid (tx_tail_valid)
   );

   // R4: a continuous write parked on the window address stays there
   p_window_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !first_q && mode_q == XM_WR && cont_q && ptr_q == A_WINDOW)
      |=> (ptr_q == A_WINDOW));
   // R3: a single-mode write takes one data byte and no more
   p_single_write_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == XM_WR && !cont_q && spent_q) |-> !wr_en);

endmodule

// File: tb/xhp_host_port_bench.sv
module xhp_host_port_bench;

   localparam int HALF = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
   logic        miso;
   logic        ev_tx = 1'b0, ev_rb = 1'b0, ev_re = 1'b0;
   logic        irq;
   logic [11:0] tx_len;
   logic [2:0]  tail_bits;
   logic        tail_valid;

   int vectors = 0;
   int fails   = 0;

   logic [7:0] exp_v[$];
   string      exp_tag[$];
   logic [7:0] wq[$];
   logic [7:0] got_val;
   event       got_ev;

   always #4 clk = ~clk;

   xhp_host_port u_xhp_host_port (
      .clk (clk), .rst_n (rst_n),
      .spi_sclk (sclk), .spi_ss_n (ss_n), .spi_mosi (mosi), .spi_miso (miso),
      .evt_tx_end (ev_tx), .evt_rx_begin (ev_rb), .evt_rx_end (ev_re),
      .irq (irq), .tx_len (tx_len), .tx_tail_bits (tail_bits), .tx_tail_valid (tail_valid)
   );

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic expect_byte(input logic [7:0] v, input string tag);
      exp_v.push_back(v);
      exp_tag.push_back(tag);
   endtask

   initial begin : monitor
      forever begin
         @(got_ev);
         if (exp_v.size() == 0) begin
            check(1'b0, "scoreboard empty", int'(got_val), 0);
         end else begin
            automatic logic [7:0] e = exp_v.pop_front();
            automatic string      t = exp_tag.pop_front();
            check(got_val == e, t, int'(got_val), int'(e));
         end
      end
   end

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      if (which == 0) ev_tx = 1'b1;
      if (which == 1) ev_rb = 1'b1;
      if (which == 2) ev_re = 1'b1;
      @(negedge clk);
      ev_tx = 1'b0; ev_rb = 1'b0; ev_re = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic rd_txn(input logic [7:0] ctl, input int n, input logic late_event);
      logic [7:0] r;
      ss_n = 1'b0;
      repeat (HALF) @(negedge clk);
      xfer(ctl, r);
      check(r == 8'h00, "R1 miso idle during control byte", int'(r), 0);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, r);
         got_val = r;
         -> got_ev;
      end
      if (late_event) pulse(0);
      repeat (HALF) @(negedge clk);
      ss_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic wr_txn(input logic [7:0] ctl);
      logic [7:0] r;
      ss_n = 1'b0;
      repeat (HALF) @(negedge clk);
      xfer(ctl, r);
      foreach (wq[k]) xfer(wq[k], r);
      wq.delete();
      repeat (HALF) @(negedge clk);
      ss_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin : stim
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R2 reset state
      check(irq == 1'b0, "R2 irq after reset", int'(irq), 0);
      check(tx_len == 12'h0, "R2 tx_len after reset", int'(tx_len), 0);
      expect_byte(8'h01, "R2/R3 single read 0x00");
      expect_byte(8'h00, "R3 single read trailing byte");
      rd_txn(8'h40, 2, 1'b0);
      expect_byte(8'h01, "R4 cont read 0x00");
      expect_byte(8'h21, "R4 cont read 0x01");
      expect_byte(8'h00, "R4 cont read 0x02");
      expect_byte(8'h00, "R4 cont read 0x03");
      rd_txn(8'h60, 4, 1'b0);
      expect_byte(8'h11, "R2 default of 0x09");
      rd_txn(8'h49, 1, 1'b0);

      // R3 single write drops the extra byte
      wq = '{8'hA5, 8'h77};
      wr_txn(8'h05);
      expect_byte(8'hA5, "R3 single write kept");
      rd_txn(8'h45, 1, 1'b0);
      expect_byte(8'h00, "R3 extra byte dropped");
      rd_txn(8'h46, 1, 1'b0);

      // R4 continuous write
      wq = '{8'hC1, 8'hC2};
      wr_txn(8'h22);
      expect_byte(8'hC1, "R4 cont write 0x02");
      expect_byte(8'hC2, "R4 cont write 0x03");
      expect_byte(8'h00, "R4 cont read 0x04");
      rd_txn(8'h62, 3, 1'b0);

      // R7 length registers, then stepping onto the window (R4/R5)
      wq = '{8'h12, 8'h3B, 8'hAA, 8'hBB};
      wr_txn(8'h3D);
      check(tx_len == 12'h123, "R7 tx_len", int'(tx_len), 'h123);
      check(tail_bits == 3'd5, "R7 tail bits", int'(tail_bits), 5);
      check(tail_valid == 1'b1, "R7 tail flag", int'(tail_valid), 1);
      expect_byte(8'h12, "R7 read 0x1D");
      rd_txn(8'h5D, 1, 1'b0);
      expect_byte(8'h3B, "R7 read 0x1E");
      rd_txn(8'h5E, 1, 1'b0);
      expect_byte(8'h02, "R6 level two");
      rd_txn(8'h5C, 1, 1'b0);
      wq = '{8'h55};
      wr_txn(8'h1C);
      expect_byte(8'h02, "R6 write to level register dropped");
      rd_txn(8'h5C, 1, 1'b0);
      wq = '{8'hFF};
      wr_txn(8'h0C);
      check(irq == 1'b0, "R9 write to status dropped", int'(irq), 0);
      expect_byte(8'hAA, "R5 first out");
      expect_byte(8'hBB, "R5 second out");
      expect_byte(8'h00, "R8 empty read gives zero");
      rd_txn(8'h7F, 3, 1'b0);
      check(irq == 1'b1, "R8/R9 underflow raises irq", int'(irq), 1);
      expect_byte(8'h08, "R8 underflow bit");
      rd_txn(8'h4C, 1, 1'b0);
      check(irq == 1'b0, "R10 irq cleared at deselect", int'(irq), 0);
      expect_byte(8'h00, "R10 status empty after clear");
      rd_txn(8'h4C, 1, 1'b0);

      // R8 overflow and R5 full-depth order
      for (int i = 0; i < 128; i++) wq.push_back(8'(i));
      wr_txn(8'h3F);
      expect_byte(8'hFF, "R6 full level");
      rd_txn(8'h5C, 1, 1'b0);
      check(irq == 1'b1, "R8 overflow raises irq", int'(irq), 1);
      expect_byte(8'h10, "R8 overflow bit");
      rd_txn(8'h4C, 1, 1'b0);
      for (int i = 0; i < 127; i++) expect_byte(8'(i), "R5 order over full depth");
      rd_txn(8'h7F, 127, 1'b0);
      expect_byte(8'h00, "R6 level after drain");
      rd_txn(8'h5C, 1, 1'b0);
      expect_byte(8'h08, "R8 trailing prefetch underflow");
      rd_txn(8'h4C, 1, 1'b0);

      // R9 event bits
      pulse(1);
      check(irq == 1'b0, "R9 rx start quiet", int'(irq), 0);
      pulse(2);
      check(irq == 1'b1, "R9 rx end raises irq", int'(irq), 1);
      expect_byte(8'h60, "R9 rx bits");
      rd_txn(8'h4C, 1, 1'b0);
      check(irq == 1'b0, "R10 cleared", int'(irq), 0);

      // R10 event after the read survives
      expect_byte(8'h00, "R10 read before late event");
      rd_txn(8'h4C, 1, 1'b1);
      check(irq == 1'b1, "R10 late event kept", int'(irq), 1);
      expect_byte(8'h80, "R9/R10 tx end bit");
      rd_txn(8'h4C, 1, 1'b0);
      check(irq == 1'b0, "R10 tx end cleared", int'(irq), 0);

      // R11 commands
      wq = '{8'h55}; wr_txn(8'h00);
      wq = '{8'h11, 8'h22}; wr_txn(8'h3F);
      wq = '{8'h40}; wr_txn(8'h1D);
      pulse(0);
      wr_txn(8'h83);
      check(irq == 1'b0, "R11 init clears status", int'(irq), 0);
      check(tx_len == 12'h0, "R11 init clears length", int'(tx_len), 0);
      expect_byte(8'h01, "R11 init restores 0x00");
      rd_txn(8'h40, 1, 1'b0);
      expect_byte(8'h00, "R11 init empties FIFO");
      rd_txn(8'h5C, 1, 1'b0);
      wq = '{8'h66}; wr_txn(8'h00);
      wr_txn(8'h85);
      expect_byte(8'h66, "R11 unknown command ignored");
      rd_txn(8'h40, 1, 1'b0);
      wr_txn(8'h80);
      expect_byte(8'h01, "R11 idle restores 0x00");
      rd_txn(8'h40, 1, 1'b0);

      repeat (20) @(negedge clk);
      check(exp_v.size() == 0, "scoreboard drained", exp_v.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule